// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands (1 sign bit, 8-bit exponent biased by 127, 23-bit fraction) and returns the correctly rounded 32-bit product with four exception flags. The caller chooses one of four rounding directions for each operation. The flags report overflow, underflow, inexact and invalid. The block accepts subnormal operands and can produce subnormal results. Zero, infinity and NaN inputs resolve to fixed results without going through the arithmetic path.

An operation is accepted on a valid/ready handshake at the input. The operands are unpacked and their significands multiplied in the first cycle. The 48-bit product is normalized, rounded and packed in the second cycle. The result is then held at the output until the consumer takes it. Only one operation is in flight at a time, so the input is not ready again until the result has been handed over.

Top module: `fpMul`

## Requirements
- R1: The sign bit of every non-NaN result is the XOR of the two operand sign bits.
- R2: For normal operands whose product is exact and in range, the result exponent field is the sum of the two exponent fields minus 127, and 127 is subtracted once only (1.5 × 2.0 gives 0x40400000).
- R3: The 24-bit significands (hidden bit included) are multiplied into a 48-bit product. When the product's top bit is set, the significand is taken one place higher and the exponent is increased by one (1.5 × 1.5 gives 0x40100000).
- R4: rndMode selects the rounding: 00 to nearest with ties to even, 01 toward zero, 10 toward plus infinity, 11 toward minus infinity. Rounding uses a guard bit, a round bit and a sticky bit. flagInexact is 1 when any discarded bit is nonzero.
- R5: When rounding carries out of the significand, the result is renormalized: the fraction becomes zero and the exponent rises by one.
- R6: A rounded exponent of 255 or more sets flagOverflow and flagInexact. The result is then infinity in modes 00, 10 (positive sign) and 11 (negative sign). In the other cases it is the largest finite magnitude (exponent 254, fraction all ones) with the product's sign.
- R7: An operand with exponent field 0 is treated as exponent 1 with a hidden bit of 0. A product whose normalized exponent is below 1 is shifted right into subnormal form, and the shifted-out bits feed the sticky bit. flagUnderflow is set when the result was tiny before rounding and is inexact. A subnormal that rounds up to the smallest normal gets exponent field 1.
- R8: Infinity times zero, or any operand that is a signaling NaN (exponent 255, fraction nonzero, fraction MSB 0), gives 0x7FC00000 with flagInvalid set. A quiet NaN operand gives 0x7FC00000 with no flag.
- R9: Infinity times a nonzero non-NaN value gives an infinity. Zero times a finite value gives a zero. In both cases the sign is the XOR of the operand signs and no flag is raised.
- R10: An operation is accepted at a rising edge where inValid and inReady are both 1. inReady and outValid are both 0 for the following cycle. outValid is 1 after the second rising edge. The result and the flags stay unchanged while outValid is 1 and outReady is 0. inReady returns to 1 after the edge at which the result is taken.
- R11: While rstN is low, outValid is 0 and inReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and rounding mode are present |
| inReady | output | 1 | Block can accept an operation |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| rndMode | input | 2 | Rounding direction select |
| outValid | output | 1 | Result and flags are valid |
| outReady | input | 1 | Consumer takes the result |
| result | output | 32 | Rounded product |
| flagOverflow | output | 1 | Result exceeded the finite range |
| flagUnderflow | output | 1 | Result tiny before rounding and inexact |
| flagInexact | output | 1 | Result differs from the exact product |
| flagInvalid | output | 1 | Infinity times zero or signaling NaN operand |

## Verification
The bench targets the exponent ends of the range. It multiplies large operands in every rounding direction: a design that always saturated to infinity, or that ignored the sign when choosing between infinity and the largest finite value, would return the wrong word. Subnormal products that land exactly halfway between representable values check tie-to-even and the sticky collection. If the right shift dropped the shifted-out bits, the design would round a tie or a nearly-zero value the wrong way, or leave out the underflow flag. Products just below a power of two catch a missing renormalization after a rounding carry, which shows up as a fraction of all zeros with the wrong exponent. Infinity-times-zero, signaling and quiet NaNs, and signed zeros catch special values that leak into the arithmetic path.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int EXT_W  = EXP_W + 3;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_ZERO      = 2'b01,
    RND_POS       = 2'b10,
    RND_NEG       = 2'b11
  } rnd_mode_e;

  typedef enum logic [1:0] {
    CLS_FINITE,
    CLS_ZERO,
    CLS_INF,
    CLS_NAN
  } res_class_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALC,
    ST_HOLD
  } ctrl_state_e;

  typedef struct packed {
    logic loadOps;
    logic loadRes;
  } dp_ctrl_t;
endpackage

// File: rtl/fpmulUnpack.sv
module fpmulUnpack
  import fpmul_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              signBit,
  output logic              isZero,
  output logic              isInf,
  output logic              isNan,
  output logic              isSignaling,
  output logic [EXP_W-1:0]  effExp,
  output logic [SIG_W-1:0]  sig
);
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic expAllOnes, expAllZero, fracZero;

  assign signBit    = word[WORD_W-1];
  assign expField   = word[WORD_W-2 -: EXP_W];
  assign fracField  = word[FRAC_W-1:0];
  assign expAllOnes = &expField;
  assign expAllZero = ~|expField;
  assign fracZero   = ~|fracField;

  assign isZero      = expAllZero & fracZero;
  assign isInf       = expAllOnes & fracZero;
  assign isNan       = expAllOnes & ~fracZero;
  assign isSignaling = isNan & ~fracField[FRAC_W-1];

  // subnormals sit at the lowest exponent with no hidden one
  assign effExp = expAllZero ? EXP_W'(1) : expField;
  assign sig    = {~expAllZero, fracField};
endmodule

// File: rtl/fpmulRound.sv
module fpmulRound
  import fpmul_pkg::*;
(
  input  logic                    sign,
  input  logic [PROD_W-1:0]       prod,
  input  logic signed [EXT_W-1:0] expSum,
  input  rnd_mode_e               mode,
  output logic [WORD_W-1:0]       word,
  output logic                    overflow,
  output logic                    underflow,
  output logic                    inexact
);
  localparam int SH_W = $clog2(PROD_W + 2);
  localparam int GRD  = PROD_W - SIG_W - 1;
  localparam logic signed [EXT_W-1:0] ONE_E     = EXT_W'(1);
  localparam logic signed [EXT_W-1:0] SH_MAX_E  = EXT_W'(PROD_W + 1);
  localparam logic signed [EXT_W-1:0] EXP_MAX_E = EXT_W'(EXP_MAX);

  function automatic logic [SH_W-1:0] leadZeros(input logic [PROD_W-1:0] v);
    logic [SH_W-1:0] n;
    logic found;
    n = '0;
    found = 1'b0;
    for (int i = PROD_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (v[i]) found = 1'b1;
        else n = n + SH_W'(1);
      end
    end
    return n;
  endfunction

  logic [SH_W-1:0]         lz, shCap;
  logic [PROD_W-1:0]       normP, shifted;
  logic [2*PROD_W-1:0]     wide;
  logic signed [EXT_W-1:0] expN, shRaw, expOut;
  logic                    denorm, guardB, roundB, stickyB, inexactRaw, up, useInf;
  logic [SIG_W-1:0]        sig;
  logic [SIG_W:0]          sumR;
  logic [FRAC_W-1:0]       fracOut;

  always_comb begin
    // bring the leading one to the top bit
    lz    = leadZeros(prod);
    normP = prod << lz;
    expN  = expSum + ONE_E - $signed(EXT_W'(lz));

    // tiny results move right into subnormal form
    denorm = expN < ONE_E;
    shRaw  = ONE_E - expN;
    if (!denorm)               shCap = '0;
    else if (shRaw > SH_MAX_E) shCap = SH_W'(PROD_W + 1);
    else                       shCap = shRaw[SH_W-1:0];
    wide    = {normP, {PROD_W{1'b0}}} >> shCap;
    shifted = wide[2*PROD_W-1:PROD_W];

    sig        = shifted[PROD_W-1 -: SIG_W];
    guardB     = shifted[GRD];
    roundB     = shifted[GRD-1];
    stickyB    = (|shifted[GRD-2:0]) | (|wide[PROD_W-1:0]);
    inexactRaw = guardB | roundB | stickyB;

    unique case (mode)
      RND_NEAR_EVEN: up = guardB & (roundB | stickyB | sig[0]);
      RND_ZERO:      up = 1'b0;
      RND_POS:       up = inexactRaw & ~sign;
      RND_NEG:       up = inexactRaw & sign;
      default:       up = 1'b0;
    endcase

    sumR = {1'b0, sig} + (SIG_W + 1)'(up);
    if (denorm) begin
      expOut  = sumR[SIG_W-1] ? ONE_E : '0;
      fracOut = sumR[FRAC_W-1:0];
    end else if (sumR[SIG_W]) begin
      expOut  = expN + ONE_E;
      fracOut = sumR[FRAC_W:1];
    end else begin
      expOut  = expN;
      fracOut = sumR[FRAC_W-1:0];
    end

    overflow  = expOut >= EXP_MAX_E;
    underflow = denorm & inexactRaw;
    inexact   = inexactRaw | overflow;
    useInf    = (mode == RND_NEAR_EVEN) | ((mode == RND_POS) & ~sign) | ((mode == RND_NEG) & sign);

    if (overflow)
      word = useInf ? {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                    : {sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    else
      word = {sign, expOut[EXP_W-1:0], fracOut};
  end
endmodule

// File: rtl/fpmulDatapath.sv
module fpmulDatapath
  import fpmul_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctrl,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [1:0]        rndMode,
  output logic [WORD_W-1:0] result,
  output logic              flagOverflow,
  output logic              flagUnderflow,
  output logic              flagInexact,
  output logic              flagInvalid
);
  localparam int N_OPS = 2;

  logic [WORD_W-1:0] opArr  [N_OPS];
  logic              sgn    [N_OPS];
  logic              zro    [N_OPS];
  logic              inf    [N_OPS];
  logic              nan    [N_OPS];
  logic              snan   [N_OPS];
  logic [EXP_W-1:0]  effExp [N_OPS];
  logic [SIG_W-1:0]  sigArr [N_OPS];

  assign opArr[0] = opA;
  assign opArr[1] = opB;

  generate
    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_unpack
      fpmulUnpack u_unpack (
        .word        (opArr[gi]),
        .signBit     (sgn[gi]),
        .isZero      (zro[gi]),
        .isInf       (inf[gi]),
        .isNan       (nan[gi]),
        .isSignaling (snan[gi]),
        .effExp      (effExp[gi]),
        .sig         (sigArr[gi])
      );
    end
  endgenerate

  // stage one: classify, multiply significands, sum exponents
  res_class_e              clsD, clsQ;
  logic                    invD, invQ, signQ;
  logic [PROD_W-1:0]       prodD, prodQ;
  logic signed [EXT_W-1:0] expSumD, expSumQ;
  rnd_mode_e               modeQ;

  always_comb begin
    invD = 1'b0;
    if (nan[0] | nan[1]) begin
      clsD = CLS_NAN;
      invD = snan[0] | snan[1];
    end else if ((inf[0] & zro[1]) | (zro[0] & inf[1])) begin
      clsD = CLS_NAN;
      invD = 1'b1;
    end else if (inf[0] | inf[1]) begin
      clsD = CLS_INF;
    end else if (zro[0] | zro[1]) begin
      clsD = CLS_ZERO;
    end else begin
      clsD = CLS_FINITE;
    end
    prodD   = PROD_W'(sigArr[0]) * PROD_W'(sigArr[1]);
    expSumD = $signed(EXT_W'(effExp[0])) + $signed(EXT_W'(effExp[1])) - $signed(EXT_W'(BIAS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clsQ    <= CLS_ZERO;
      invQ    <= 1'b0;
      signQ   <= 1'b0;
      prodQ   <= '0;
      expSumQ <= '0;
      modeQ   <= RND_NEAR_EVEN;
    end else if (ctrl.loadOps) begin
      clsQ    <= clsD;
      invQ    <= invD;
      signQ   <= sgn[0] ^ sgn[1];
      prodQ   <= prodD;
      expSumQ <= expSumD;
      modeQ   <= rnd_mode_e'(rndMode);
    end
  end

  // stage two: normalize, round, pack
  logic [WORD_W-1:0] rndWord;
  logic              rndOvf, rndUnf, rndInx;

  fpmulRound u_round (
    .sign      (signQ),
    .prod      (prodQ),
    .expSum    (expSumQ),
    .mode      (modeQ),
    .word      (rndWord),
    .overflow  (rndOvf),
    .underflow (rndUnf),
    .inexact   (rndInx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result        <= '0;
      flagOverflow  <= 1'b0;
      flagUnderflow <= 1'b0;
      flagInexact   <= 1'b0;
      flagInvalid   <= 1'b0;
    end else if (ctrl.loadRes) begin
      flagOverflow  <= 1'b0;
      flagUnderflow <= 1'b0;
      flagInexact   <= 1'b0;
      flagInvalid   <= 1'b0;
      unique case (clsQ)
        CLS_NAN: begin
          result      <= QNAN_WORD;
          flagInvalid <= invQ;
        end
        CLS_INF:  result <= {signQ, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        CLS_ZERO: result <= {signQ, {(WORD_W-1){1'b0}}};
        default: begin
          result        <= rndWord;
          flagOverflow  <= rndOvf;
          flagUnderflow <= rndUnf;
          flagInexact   <= rndInx;
        end
      endcase
    end
  end

  // R1
  sign_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadRes && clsQ != CLS_NAN) |=> result[WORD_W-1] == $past(signQ));

  // R6
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagOverflow |-> (flagInexact && !flagUnderflow && result[WORD_W-2 -: EXP_W] >= EXP_W'(EXP_MAX - 1)));

  // R7
  unf_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagUnderflow |-> (flagInexact && result[WORD_W-2 -: EXP_W] <= EXP_W'(1)));

  // R8
  inv_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalid |-> (result == QNAN_WORD && !flagInexact && !flagOverflow));
endmodule

// File: rtl/fpmulControl.sv
module fpmulControl
  import fpmul_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output dp_ctrl_t ctrl
);
  ctrl_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (inValid) stateNext = ST_CALC;
      ST_CALC: stateNext = ST_HOLD;
      ST_HOLD: if (outReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign inReady      = state == ST_IDLE;
  assign outValid     = state == ST_HOLD;
  assign ctrl.loadOps = inReady & inValid;
  assign ctrl.loadRes = state == ST_CALC;

  // R10
  accept_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (!inReady && !outValid));

  // R10
  accept_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> ##1 outValid);

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> inReady);
endmodule

// File: rtl/fpMul.sv
module fpMul
  import fpmul_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [1:0]  rndMode,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] result,
  output logic        flagOverflow,
  output logic        flagUnderflow,
  output logic        flagInexact,
  output logic        flagInvalid
);
  dp_ctrl_t ctrl;

  fpmulControl u_control (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .ctrl     (ctrl)
  );

  fpmulDatapath u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .opA           (opA),
    .opB           (opB),
    .rndMode       (rndMode),
    .result        (result),
    .flagOverflow  (flagOverflow),
    .flagUnderflow (flagUnderflow),
    .flagInexact   (flagInexact),
    .flagInvalid   (flagInvalid)
  );

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(result) && $stable(flagOverflow)
      && $stable(flagUnderflow) && $stable(flagInexact) && $stable(flagInvalid)));
endmodule

// File: tb/test_fpMul.sv
`timescale 1ns/1ps
module test_fpMul;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        outReady = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [1:0]  rndMode = '0;
  logic        inReady, outValid;
  logic [31:0] result;
  logic        flagOverflow, flagUnderflow, flagInexact, flagInvalid;

  fpMul i_fpMul (
    .clk (clk), .rstN (rstN), .inValid (inValid), .inReady (inReady),
    .opA (opA), .opB (opB), .rndMode (rndMode), .outValid (outValid),
    .outReady (outReady), .result (result), .flagOverflow (flagOverflow),
    .flagUnderflow (flagUnderflow), .flagInexact (flagInexact), .flagInvalid (flagInvalid)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [31:0] res;
    logic ovf, unf, inx, inv;
  } expect_t;

  logic [31:0] vecA[$];
  logic [31:0] vecB[$];
  logic [1:0]  vecM[$];
  string       vecTag[$];
  expect_t     expQ[$];
  string       tagQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic check(bit ok, string tag, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic addVec(string tag, logic [31:0] a, logic [31:0] b, logic [1:0] m);
    vecA.push_back(a);
    vecB.push_back(b);
    vecM.push_back(m);
    vecTag.push_back(tag);
  endtask

  // behavioural model: exact integer product, then bit-at-a-time shifting
  function automatic expect_t refMul(logic [31:0] a, logic [31:0] b, logic [1:0] m);
    expect_t e;
    bit sgn, aNan, bNan, aInf, bInf, aZero, bZero, half, low, tiny, up, useInf;
    int ea, eb, k, biased;
    longint ma, mb, x;
    e = '0;
    sgn   = a[31] ^ b[31];
    aNan  = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bNan  = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    aInf  = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    bInf  = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    aZero = (a[30:0] == 0);
    bZero = (b[30:0] == 0);
    if (aNan || bNan) begin
      e.res = 32'h7FC00000;
      e.inv = (aNan && !a[22]) || (bNan && !b[22]);
      return e;
    end
    if ((aInf && bZero) || (bInf && aZero)) begin
      e.res = 32'h7FC00000;
      e.inv = 1'b1;
      return e;
    end
    if (aInf || bInf) begin
      e.res = {sgn, 8'hFF, 23'd0};
      return e;
    end
    if (aZero || bZero) begin
      e.res = {sgn, 31'd0};
      return e;
    end
    ea = (a[30:23] == 0) ? 1 : int'(a[30:23]);
    eb = (b[30:23] == 0) ? 1 : int'(b[30:23]);
    ma = (a[30:23] == 0) ? longint'(a[22:0]) : longint'({1'b1, a[22:0]});
    mb = (b[30:23] == 0) ? longint'(b[22:0]) : longint'({1'b1, b[22:0]});
    x = ma * mb;
    k = ea + eb - 300;
    while (x < (64'd1 << 23) && k + 150 > 1) begin
      x = x << 1;
      k--;
    end
    half = 0;
    low = 0;
    while (x >= (64'd1 << 24) || k + 150 < 1) begin
      low  = low | half;
      half = (x & 1) != 0;
      x = x >> 1;
      k++;
    end
    tiny  = x < (64'd1 << 23);
    e.inx = half | low;
    case (m)
      2'b00:   up = half && (low || ((x & 1) != 0));
      2'b01:   up = 0;
      2'b10:   up = e.inx && !sgn;
      default: up = e.inx && sgn;
    endcase
    if (up) x = x + 1;
    if (x == (64'd1 << 24)) begin
      x = x >> 1;
      k++;
    end
    biased = (x >= (64'd1 << 23)) ? k + 150 : 0;
    e.unf = tiny && e.inx;
    if (biased >= 255) begin
      e.ovf = 1;
      e.inx = 1;
      e.unf = 0;
      useInf = (m == 2'b00) || (m == 2'b10 && !sgn) || (m == 2'b11 && sgn);
      e.res = useInf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, 23'h7FFFFF};
    end else begin
      e.res = {sgn, 8'(biased), x[22:0]};
    end
    return e;
  endfunction

  function automatic logic [31:0] randOp();
    int sel;
    logic [7:0] ex;
    logic [31:0] w;
    sel = $urandom_range(0, 11);
    if (sel < 5)       ex = 8'($urandom_range(100, 154));
    else if (sel < 7)  ex = 8'($urandom_range(0, 20));
    else if (sel < 9)  ex = 8'($urandom_range(200, 254));
    else if (sel == 9) ex = 8'd0;
    else if (sel == 10) ex = 8'hFF;
    else               ex = 8'($urandom_range(1, 254));
    w = {1'($urandom_range(0, 1)), ex, 23'($urandom)};
    if (sel >= 9 && sel <= 10 && $urandom_range(0, 1) == 0) w[22:0] = '0;
    return w;
  endfunction

  initial begin
    int idx, cyc, acceptCyc;
    expect_t act;
    // R2 exponent sum, R1 sign, R3 top-bit normalization
    addVec("R2", 32'h3FC00000, 32'h40000000, 2'b00);
    addVec("R1", 32'hC0000000, 32'h40400000, 2'b00);
    addVec("R3", 32'h3FC00000, 32'h3FC00000, 2'b00);
    for (int m = 0; m < 4; m++) begin
      addVec("R4", 32'h3F800001, 32'h3F800001, 2'(m));
      addVec("R4", 32'hBF800001, 32'h3FAAAAAB, 2'(m));
      addVec("R6", 32'h7F000000, 32'h7F000000, 2'(m));
      addVec("R6", 32'hFF000000, 32'h7F000000, 2'(m));
    end
    // R5 rounding carry into a new bit
    addVec("R5", 32'h3F800001, 32'h3F7FFFFE, 2'b00);
    addVec("R5", 32'h3F800001, 32'h3F7FFFFE, 2'b01);
    // R7 subnormal inputs and outputs
    addVec("R7", 32'h00000001, 32'h3F800000, 2'b00);
    addVec("R7", 32'h00000001, 32'h3F000000, 2'b00);
    addVec("R7", 32'h00000001, 32'h3F000000, 2'b10);
    addVec("R7", 32'h00800000, 32'h3F000000, 2'b00);
    addVec("R7", 32'h00400000, 32'h40800000, 2'b00);
    addVec("R7", 32'h00800001, 32'h3F000000, 2'b00);
    addVec("R7", 32'h00FFFFFF, 32'h3F7FFFFF, 2'b10);
    addVec("R7", 32'h0DA24260, 32'h0DA24260, 2'b00);
    // R8 invalid and NaN
    addVec("R8", 32'h7F800000, 32'h00000000, 2'b00);
    addVec("R8", 32'h80000000, 32'hFF800000, 2'b00);
    addVec("R8", 32'h7FC00000, 32'h3F800000, 2'b00);
    addVec("R8", 32'h7F800001, 32'h3F800000, 2'b00);
    // R9 infinities and signed zeros
    addVec("R9", 32'hFF800000, 32'h3F800000, 2'b00);
    addVec("R9", 32'h7F800000, 32'h00000001, 2'b00);
    addVec("R9", 32'h80000000, 32'h3F800000, 2'b00);
    addVec("R9", 32'h00000000, 32'h80000001, 2'b00);
    for (int i = 0; i < 400; i++) addVec("R4", randOp(), randOp(), 2'($urandom_range(0, 3)));

    // R11 reset state
    repeat (3) @(negedge clk);
    check(outValid == 0 && inReady == 1, "R11",
          $sformatf("in reset outValid=%b inReady=%b exp 0/1", outValid, inReady));
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 0 && inReady == 1, "R11",
          $sformatf("after reset outValid=%b inReady=%b exp 0/1", outValid, inReady));

    idx = 0;
    cyc = 0;
    acceptCyc = -10;
    while (idx < vecA.size() || expQ.size() != 0) begin
      @(negedge clk);
      cyc++;
      outReady = ($urandom_range(0, 3) != 0);
      if (idx < vecA.size()) begin
        inValid = 1'b1;
        opA = vecA[idx];
        opB = vecB[idx];
        rndMode = vecM[idx];
      end else begin
        inValid = 1'b0;
      end
      #0.1;
      if (cyc == acceptCyc + 1)
        check(!inReady && !outValid, "R10",
              $sformatf("cycle after accept inReady=%b outValid=%b exp 0/0", inReady, outValid));
      if (cyc == acceptCyc + 2)
        check(outValid, "R10", $sformatf("second cycle after accept outValid=%b exp 1", outValid));
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(0, "R10", "outValid=1 exp no pending result");
        end else begin
          act = {result, flagOverflow, flagUnderflow, flagInexact, flagInvalid};
          check(act == expQ[0], tagQ[0],
                $sformatf("res=%h ovf=%b unf=%b inx=%b inv=%b exp res=%h ovf=%b unf=%b inx=%b inv=%b",
                          act.res, act.ovf, act.unf, act.inx, act.inv,
                          expQ[0].res, expQ[0].ovf, expQ[0].unf, expQ[0].inx, expQ[0].inv));
          if (outReady) begin
            void'(expQ.pop_front());
            void'(tagQ.pop_front());
          end
        end
      end
      if (inValid && inReady) begin
        expQ.push_back(refMul(opA, opB, rndMode));
        tagQ.push_back(vecTag[idx]);
        idx++;
        acceptCyc = cyc;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10: watchdog expired, outValid=%b inReady=%b exp completion", outValid, inReady);
    finishRun();
  end
endmodule